// File: doc/BRIEF.md
# Block coefficient run-length tokenizer

This block turns one block of 64 quantized transform coefficients, already in zig-zag order, into a stream of entropy-coder tokens. Coefficients arrive one per clock over a valid/ready handshake. Every token leaves with a token code, its extra bits, the count of extra bits that are meaningful, and the zig-zag position of the first coefficient it stands for. A later stage packs the tokens into a bitstream.

Nonzero values become value tokens. A run of zeros that a nonzero coefficient ends becomes a run token that carries the run length. Zeros that reach the end of the block become one end-of-block token, because that costs far fewer bits than an explicit run. The final token of each block carries a last flag. Whether a zero run is interior or trailing is not known until a nonzero value arrives or position 63 is reached, so the block defers that decision. When a nonzero value ends a run, two tokens result from one coefficient, and the second token waits in a one-entry holding slot.

Top module: `tokzz_top`

## Requirements
- R1: Coefficients are taken in order at positions 0 through 63, then the count wraps to 0 for the next block. The tokens of one block cover exactly 64 positions: a run token covers its run length, an end-of-block token covers every position from its index through 63, and every other token covers one position. Each token's index equals the number of positions that the earlier tokens of the same block cover.
- R2: A coefficient of +1 yields code 9 with 0 extra bits.
- R3: A coefficient of -1 yields code 10 with 0 extra bits.
- R4: Any other nonzero coefficient yields code 22 with 10 extra bits. Bit 9 is the sign (1 = negative) and bits 8:0 hold the magnitude, saturated to 511. The input is 16-bit signed, so -32768 gives magnitude 511.
- R5: One or more zeros followed by a nonzero coefficient in the same block yield code 8 with 6 extra bits. The extra bits hold the run length in plain binary (1 to 63), and the index is the position of the first zero. The value token follows at once.
- R6: Zeros that run through position 63 yield one token with code 0 and 0 extra bits, at the index of the first of those zeros. This is never a run token. A block of all zeros yields only this token, at index 0.
- R7: tok_last_o is high on the final token of each block and low on every other token.
- R8: While tok_valid_o is high and tok_ready_i is low, every token output stays stable. coef_ready_o stays low whenever the block cannot take a coefficient, so no coefficient or token is lost under backpressure.
- R9: After reset, tok_valid_o is low and, with tok_ready_i high, coef_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_i | input | 16 | Quantized coefficient, signed |
| coef_valid_i | input | 1 | Coefficient valid |
| coef_ready_o | output | 1 | Coefficient accepted when high with valid |
| tok_valid_o | output | 1 | Token valid |
| tok_ready_i | input | 1 | Downstream accepts token |
| tok_code_o | output | 5 | Token code |
| tok_extra_o | output | 10 | Extra bits, right-aligned |
| tok_nbits_o | output | 4 | Number of meaningful extra bits |
| tok_index_o | output | 6 | Zig-zag position where the token starts |
| tok_last_o | output | 1 | Final token of the block |

## Verification
On every cycle the assertions check the shape of each token against its code: the extra-bit count, a nonzero run length, and the last flag on end-of-block tokens. They also check that token indices are contiguous, that each block covers exactly 64 positions, and that outputs stay stable and input stays blocked while the output is stalled. Only the bench scenarios can show that the right code and value come out for a given coefficient pattern. Those scenarios include saturation of large magnitudes, a run of 63, a block of all zeros, and the choice between a trailing end-of-block token and an interior run, with and without downstream backpressure.

// File: rtl/tokzz_pkg.sv
package tokzz_pkg;
  localparam int BLK_LEN  = 64;
  localparam int IDX_W    = $clog2(BLK_LEN);
  localparam int MAG_W    = 9;
  localparam int EXTRA_W  = MAG_W + 1;
  localparam int CODE_W   = 5;
  localparam int NBITS_W  = $clog2(EXTRA_W + 1);

  localparam logic [CODE_W-1:0] CODE_EOB  = 5'd0;
  localparam logic [CODE_W-1:0] CODE_RUN  = 5'd8;
  localparam logic [CODE_W-1:0] CODE_POS1 = 5'd9;
  localparam logic [CODE_W-1:0] CODE_NEG1 = 5'd10;
  localparam logic [CODE_W-1:0] CODE_BIG  = 5'd22;

  localparam logic [NBITS_W-1:0] NB_NONE = '0;
  localparam logic [NBITS_W-1:0] NB_RUN  = NBITS_W'(IDX_W);
  localparam logic [NBITS_W-1:0] NB_BIG  = NBITS_W'(EXTRA_W);

  typedef struct packed {
    logic [CODE_W-1:0]  code;
    logic [EXTRA_W-1:0] extra;
    logic [NBITS_W-1:0] nbits;
    logic [IDX_W-1:0]   index;
    logic               last;
  } tok_t;
endpackage

// File: rtl/tokzz_value_map.sv
module tokzz_value_map
  import tokzz_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic [COEF_W-1:0]  coef_i,
  output logic               zero_o,
  output logic [CODE_W-1:0]  code_o,
  output logic [EXTRA_W-1:0] extra_o,
  output logic [NBITS_W-1:0] nbits_o
);
  localparam logic [COEF_W-1:0] MAG_MAX = COEF_W'((1 << MAG_W) - 1);

  logic              neg;
  logic [COEF_W-1:0] mag;
  logic [MAG_W-1:0]  mag_sat;

  always_comb begin
    neg     = coef_i[COEF_W-1];
    mag     = neg ? (~coef_i + 1'b1) : coef_i;  // -min wraps to 2^(W-1) unsigned
    mag_sat = (mag > MAG_MAX) ? MAG_MAX[MAG_W-1:0] : mag[MAG_W-1:0];
    zero_o  = (coef_i == '0);
    if (coef_i == COEF_W'(1)) begin
      code_o  = CODE_POS1;
      extra_o = '0;
      nbits_o = NB_NONE;
    end else if (coef_i == {COEF_W{1'b1}}) begin
      code_o  = CODE_NEG1;
      extra_o = '0;
      nbits_o = NB_NONE;
    end else begin
      code_o  = CODE_BIG;
      extra_o = {neg, mag_sat};
      nbits_o = NB_BIG;
    end
  end
endmodule

// File: rtl/tokzz_run_track.sv
module tokzz_run_track
  import tokzz_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             zero_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] run_o,
  output logic [IDX_W-1:0] run_start_o,
  output logic             at_end_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_LEN - 1);

  assign at_end_o = (idx_o == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o       <= '0;
      run_o       <= '0;
      run_start_o <= '0;
    end else if (take_i) begin
      idx_o <= at_end_o ? '0 : idx_o + 1'b1;
      if (zero_i && !at_end_o) begin
        if (run_o == '0) run_start_o <= idx_o;
        run_o <= run_o + 1'b1;
      end else begin
        run_o <= '0;
      end
    end
  end
endmodule

// File: rtl/tokzz_out_slot.sv
module tokzz_out_slot
  import tokzz_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_a_i,
  input  tok_t tok_a_i,
  input  logic push_b_i,
  input  tok_t tok_b_i,
  input  logic ready_i,
  output logic free_o,
  output logic hold_o,
  output logic valid_o,
  output tok_t tok_o
);
  tok_t pend_q;

  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hold_o  <= 1'b0;
      tok_o   <= '0;
      pend_q  <= '0;
    end else if (free_o) begin
      if (hold_o) begin
        tok_o   <= pend_q;
        valid_o <= 1'b1;
        hold_o  <= 1'b0;
      end else if (push_a_i) begin
        tok_o   <= tok_a_i;
        valid_o <= 1'b1;
        if (push_b_i) begin
          pend_q <= tok_b_i;
          hold_o <= 1'b1;
        end
      end else begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tokzz_top.sv
module tokzz_top
  import tokzz_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [COEF_W-1:0]  coef_i,
  input  logic               coef_valid_i,
  output logic               coef_ready_o,
  output logic               tok_valid_o,
  input  logic               tok_ready_i,
  output logic [CODE_W-1:0]  tok_code_o,
  output logic [EXTRA_W-1:0] tok_extra_o,
  output logic [NBITS_W-1:0] tok_nbits_o,
  output logic [IDX_W-1:0]   tok_index_o,
  output logic               tok_last_o
);
  logic               zero, at_end, take, slot_free, slot_hold;
  logic [CODE_W-1:0]  v_code;
  logic [EXTRA_W-1:0] v_extra;
  logic [NBITS_W-1:0] v_nbits;
  logic [IDX_W-1:0]   idx, run, run_start;
  logic               push_a, push_b;
  tok_t               tok_a, tok_b, run_tok, val_tok, eob_tok, tok_q;

  tokzz_value_map #(.COEF_W(COEF_W)) u_map (
    .coef_i (coef_i),
    .zero_o (zero),
    .code_o (v_code),
    .extra_o(v_extra),
    .nbits_o(v_nbits)
  );

  tokzz_run_track u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .zero_i     (zero),
    .idx_o      (idx),
    .run_o      (run),
    .run_start_o(run_start),
    .at_end_o   (at_end)
  );

  assign coef_ready_o = slot_free && !slot_hold;
  assign take         = coef_valid_i && coef_ready_o;

  always_comb begin
    run_tok = '{code: CODE_RUN, extra: EXTRA_W'(run), nbits: NB_RUN,
                index: run_start, last: 1'b0};
    val_tok = '{code: v_code, extra: v_extra, nbits: v_nbits,
                index: idx, last: at_end};
    eob_tok = '{code: CODE_EOB, extra: '0, nbits: NB_NONE,
                index: (run != '0) ? run_start : idx, last: 1'b1};
    push_a = 1'b0;
    push_b = 1'b0;
    tok_a  = val_tok;
    tok_b  = val_tok;
    if (take) begin
      if (zero) begin
        push_a = at_end;
        tok_a  = eob_tok;
      end else if (run != '0) begin
        // run ends here: emit run now, park the value token
        push_a = 1'b1;
        tok_a  = run_tok;
        push_b = 1'b1;
      end else begin
        push_a = 1'b1;
      end
    end
  end

  tokzz_out_slot u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_a_i(push_a),
    .tok_a_i (tok_a),
    .push_b_i(push_b),
    .tok_b_i (tok_b),
    .ready_i (tok_ready_i),
    .free_o  (slot_free),
    .hold_o  (slot_hold),
    .valid_o (tok_valid_o),
    .tok_o   (tok_q)
  );

  assign tok_code_o  = tok_q.code;
  assign tok_extra_o = tok_q.extra;
  assign tok_nbits_o = tok_q.nbits;
  assign tok_index_o = tok_q.index;
  assign tok_last_o  = tok_q.last;
endmodule

// File: rtl/tokzz_chk.sv
module tokzz_chk
  import tokzz_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               coef_ready_o,
  input logic               tok_valid_o,
  input logic               tok_ready_i,
  input logic [CODE_W-1:0]  tok_code_o,
  input logic [EXTRA_W-1:0] tok_extra_o,
  input logic [NBITS_W-1:0] tok_nbits_o,
  input logic [IDX_W-1:0]   tok_index_o,
  input logic               tok_last_o
);
  logic             fire;
  logic [IDX_W:0]   pos_q, adv;

  assign fire = tok_valid_o && tok_ready_i;

  always_comb begin
    if (tok_code_o == CODE_RUN)      adv = {1'b0, tok_extra_o[IDX_W-1:0]};
    else if (tok_code_o == CODE_EOB) adv = (IDX_W+1)'(BLK_LEN) - {1'b0, tok_index_o};
    else                             adv = (IDX_W+1)'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pos_q <= '0;
    else if (fire) pos_q <= tok_last_o ? '0 : pos_q + adv;
  end

  AST_INDEX_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> ({1'b0, tok_index_o} == pos_q));  // R1
  AST_BLOCK_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && tok_last_o) |-> (pos_q + adv == (IDX_W+1)'(BLK_LEN)));  // R1
  AST_POS1_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_code_o == CODE_POS1) |-> (tok_nbits_o == NB_NONE));  // R2
  AST_NEG1_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_code_o == CODE_NEG1) |-> (tok_nbits_o == NB_NONE));  // R3
  AST_BIG_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_code_o == CODE_BIG) |->
      (tok_nbits_o == NB_BIG && tok_extra_o[MAG_W-1:0] > MAG_W'(1)));  // R4
  AST_RUN_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_code_o == CODE_RUN) |->
      (tok_nbits_o == NB_RUN && tok_extra_o != '0 && !tok_last_o));  // R5
  AST_EOB_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_code_o == CODE_EOB) |-> (tok_nbits_o == NB_NONE && tok_last_o));  // R6
  AST_LAST_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_last_o) |->
      (tok_code_o == CODE_EOB || tok_index_o == IDX_W'(BLK_LEN - 1)));  // R7
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && !tok_ready_i) |=>
      (tok_valid_o && $stable(tok_code_o) && $stable(tok_extra_o) && $stable(tok_nbits_o)
       && $stable(tok_index_o) && $stable(tok_last_o)));  // R8
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && !tok_ready_i) |-> !coef_ready_o);  // R8
endmodule

bind tokzz_top tokzz_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .coef_ready_o(coef_ready_o),
  .tok_valid_o (tok_valid_o),
  .tok_ready_i (tok_ready_i),
  .tok_code_o  (tok_code_o),
  .tok_extra_o (tok_extra_o),
  .tok_nbits_o (tok_nbits_o),
  .tok_index_o (tok_index_o),
  .tok_last_o  (tok_last_o)
);

// File: tb/tokzz_top_test.sv
module tokzz_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] coef_i = '0;
  logic        coef_valid_i = 1'b0;
  logic        coef_ready_o;
  logic        tok_valid_o;
  logic        tok_ready_i = 1'b1;
  logic [4:0]  tok_code_o;
  logic [9:0]  tok_extra_o;
  logic [3:0]  tok_nbits_o;
  logic [5:0]  tok_index_o;
  logic        tok_last_o;

  always #10 clk_i = ~clk_i;

  tokzz_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .coef_i(coef_i), .coef_valid_i(coef_valid_i),
    .coef_ready_o(coef_ready_o), .tok_valid_o(tok_valid_o), .tok_ready_i(tok_ready_i),
    .tok_code_o(tok_code_o), .tok_extra_o(tok_extra_o), .tok_nbits_o(tok_nbits_o),
    .tok_index_o(tok_index_o), .tok_last_o(tok_last_o)
  );

  typedef struct {
    int code; int extra; int nbits; int index; bit last;
  } etok_t;

  etok_t       exp_q[$];
  int          blk[64];
  int          checks = 0, fails = 0, pos = 0;
  bit          bp_mode = 1'b0, done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic string req_of(input int code);
    case (code)
      0: return "R6";
      8: return "R5";
      9: return "R2";
      10: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic etok_t val_tok(input int v, input int i);
    etok_t t;
    int    mag;
    t.index = i;
    t.last  = (i == 63);
    if (v == 1)       begin t.code = 9;  t.extra = 0; t.nbits = 0; end
    else if (v == -1) begin t.code = 10; t.extra = 0; t.nbits = 0; end
    else begin
      mag = (v < 0) ? -v : v;
      if (mag > 511) mag = 511;
      t.code = 22; t.nbits = 10; t.extra = ((v < 0) ? 512 : 0) + mag;
    end
    return t;
  endfunction

  // model from the requirements, then drive the block
  task automatic send_block();
    int    run = 0, start = 0;
    etok_t t;
    for (int i = 0; i < 64; i++) begin
      if (blk[i] == 0) begin
        if (run == 0) start = i;
        run++;
      end else begin
        if (run > 0) begin
          t.code = 8; t.extra = run; t.nbits = 6; t.index = start; t.last = 1'b0;
          exp_q.push_back(t);
        end
        exp_q.push_back(val_tok(blk[i], i));
        run = 0;
      end
    end
    if (run > 0) begin
      t.code = 0; t.extra = 0; t.nbits = 0; t.index = start; t.last = 1'b1;
      exp_q.push_back(t);
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_i);
      coef_i = 16'(blk[i]);
      coef_valid_i = 1'b1;
      #2;
      while (!coef_ready_o) begin
        @(negedge clk_i);
        #2;
      end
      @(posedge clk_i);
    end
    @(negedge clk_i);
    coef_valid_i = 1'b0;
  endtask

  task automatic clear_blk();
    for (int i = 0; i < 64; i++) blk[i] = 0;
  endtask

  // monitor: drives ready at negedge, compares tokens that will handshake
  initial begin
    etok_t e;
    forever begin
      @(negedge clk_i);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tok_ready_i = bp_mode ? lfsr[0] : 1'b1;
      #1;
      if (rst_ni && tok_valid_o && tok_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected token code", int'(tok_code_o), -1);
        end else begin
          e = exp_q.pop_front();
          check(int'(tok_code_o) == e.code, req_of(e.code), "code", int'(tok_code_o), e.code);
          check(int'(tok_extra_o) == e.extra, req_of(e.code), "extra", int'(tok_extra_o), e.extra);
          check(int'(tok_nbits_o) == e.nbits, req_of(e.code), "nbits", int'(tok_nbits_o), e.nbits);
          check(int'(tok_index_o) == e.index, "R1", "index", int'(tok_index_o), e.index);
          check(tok_last_o == e.last, "R7", "last", int'(tok_last_o), int'(e.last));
        end
        if (tok_code_o == 5'd8)      pos += int'(tok_extra_o[5:0]);
        else if (tok_code_o == 5'd0) pos += 64 - int'(tok_index_o);
        else                         pos += 1;
        if (tok_last_o) begin
          check(pos == 64, "R1", "positions per block", pos, 64);
          pos = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "R8", "watchdog expired, tokens pending", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    check(tok_valid_o == 1'b0, "R9", "tok_valid after reset", int'(tok_valid_o), 0);
    check(coef_ready_o == 1'b1, "R9", "coef_ready after reset", int'(coef_ready_o), 1);

    for (int pass = 0; pass < 2; pass++) begin
      bp_mode = (pass == 1);
      // R5 R6: interior run of 62
      clear_blk(); blk[0] = 1; blk[63] = 1; send_block();
      // R5: run of 61 after two values
      clear_blk(); blk[0] = 1; blk[1] = 1; blk[63] = 1; send_block();
      // R6: all zero block
      clear_blk(); send_block();
      // R3 R6: trailing zeros after a run
      clear_blk(); blk[0] = -1; blk[5] = 1; send_block();
      // R2 R3 R4: dense block, saturation of large values
      for (int i = 0; i < 64; i++)
        blk[i] = (i % 3 == 0) ? 1 : (i % 3 == 1) ? -1 : 100 + i * 10;
      send_block();
      // R5 R4: run of 63 then most negative value
      clear_blk(); blk[63] = -32768; send_block();
      // R4: magnitude boundaries
      clear_blk(); blk[0] = 600; blk[1] = -512; blk[2] = 511; blk[3] = -2; blk[4] = 2;
      blk[5] = 32767; send_block();
      // R6: zero DC then value then trailing zeros
      clear_blk(); blk[1] = 7; send_block();
    end
    bp_mode = 1'b1;
    for (int b = 0; b < 10; b++) begin
      for (int i = 0; i < 64; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        blk[i] = (lfsr[2:0] == 3'd0) ? $signed({{6{lfsr[13]}}, lfsr[12:3]}) : 0;
      end
      if (b % 2 == 1) blk[63] = 3;
      send_block();
    end
    bp_mode = 1'b0;
    for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(posedge clk_i);
    repeat (4) @(posedge clk_i);
    check(exp_q.size() == 0, "R8", "tokens missing at end", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule